// File: doc/BRIEF.md
# Phase-Compensation Transmit FIFO

This block takes 16-bit words captured on a clock returned by an upstream device. It hands them, one word per cycle, to logic running on a local word clock. Both clocks run at the same nominal rate, but the phase between them is unknown and drifts slowly. The storage is a five-entry ring. The writer and the reader never stall. A controlled reset sets the spacing between the two ring pointers. After that, the ring absorbs phase drift of up to one word period in either direction.

The single reset input `rst_n` is active low and has two uses. A pulse of at least five word periods initialises the pointers and clears the storage. Holding it low permanently turns the block into a transparent path from `din` to `rdata`. The write side watches the spacing between the write pointer and a synchronised copy of the read pointer. When drift pushes that spacing out of its safe window, the active-low `warn_n` output goes low. It stays low for at least five write-clock cycles, and for as long as the bad spacing lasts. An external controller can use it to reset the block.

Top module: `phase_fifo`

## Requirements
- R1: While `rst_n` is low, `rdata` takes the value of `din` on every rising edge of `rclk` (transparent path with no storage).
- R2: While `rst_n` is low, `warn_n` is high.
- R3: After `rst_n` rises, each side leaves reset through a two-flop synchroniser. The read side then delivers exactly two all-zero words before the first stored word.
- R4: The first stored word is the `din` value present at the third rising `wclk` edge after `rst_n` rises. It appears on the fifth `rdata` update after the release.
- R5: When the write clock's phase drifts later or earlier by up to one full word period after initialisation, `warn_n` stays high and `rdata` carries consecutive words with none lost or repeated.
- R6: On the write side, the spacing is (write pointer index − synchronised read pointer index) mod 5. It is 3 at nominal phase. When it falls outside 2..4, `warn_n` goes low at the next `wclk` edge. A late drift of two periods causes this.
- R7: A drift of the write clock two periods earlier also drives `warn_n` low.
- R8: Once low, `warn_n` stays low for at least five `wclk` cycles. It stays low for as long as the bad spacing lasts, and the ring keeps running.
- R9: Reasserting `rst_n` clears the warning. A fresh release restores the nominal spacing, with `warn_n` high and the R3/R4 start-up sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low initialise / transparent-mode control, asynchronous assert |
| wclk | input | 1 | Write clock returned by the upstream device |
| din | input | 16 | Data word captured on rising `wclk` |
| warn_n | output | 1 | Active-low pointer-collision warning, `wclk` domain |
| rclk | input | 1 | Local word clock for the read side |
| rdata | output | 16 | Word delivered on each rising `rclk` |

## Verification
At reset release, the read side can leave its synchroniser while the write side is still held. In that window, the transparent path and the first reads from the ring fall in neighbouring `rclk` cycles. The bench releases reset half a nanosecond after a write edge, with the read clock half a period behind. It then checks the exact sequence of `rdata` samples: two bypass words, two zero words, then the word captured on the third write edge. The warning and a new reset also meet: reset is reasserted while `warn_n` is held low by a persistent collision. The bench judges this by `warn_n` returning high inside the reset window, followed by a clean start-up.

// File: rtl/phf_pkg.sv
package phf_pkg;

  // Position of the lowest set bit of a one-hot ring value (0 when empty).
  function automatic int unsigned oh_index(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Ring distance from trail forward to lead.
  function automatic int unsigned ring_gap(input int unsigned lead,
                                           input int unsigned trail,
                                           input int unsigned depth);
    return (lead + depth - trail) % depth;
  endfunction

  // True when a measured gap lies outside nom +/- slack.
  function automatic logic gap_bad(input int unsigned gap,
                                   input int unsigned nom,
                                   input int unsigned slack);
    return ((gap + slack) < nom) || (gap > (nom + slack));
  endfunction

endpackage

// File: rtl/phf_run_sync.sv
module phf_run_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign run = sh[STAGES-1];
endmodule

// File: rtl/phf_wr_side.sv
module phf_wr_side
  import phf_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEPTH    = 5,
  parameter int START    = 2,
  parameter int SYNC     = 2,
  parameter int SLACK    = 1,
  parameter int WARN_MIN = 5
) (
  input  logic                      wclk,
  input  logic                      w_run,
  input  logic [W-1:0]              din,
  input  logic [DEPTH-1:0]          rd_ptr,
  output logic [DEPTH-1:0][W-1:0]   store,
  output logic                      warn_n
);
  // The read pointer reaches this domain through the sync chain.
  // At nominal phase, that lag adds one entry to the starting offset.
  localparam int GAP_NOM = START + SYNC - 1;
  localparam int CW      = $clog2(WARN_MIN + 1);
  localparam logic [DEPTH-1:0] WR_HOME = DEPTH'(1) << START;
  localparam logic [DEPTH-1:0] RD_HOME = DEPTH'(1);

  logic [DEPTH-1:0] wptr;
  logic [DEPTH-1:0] rsync [SYNC];
  logic [CW-1:0]    hold_cnt;
  int unsigned      gap;
  logic             alarm;

  always_ff @(posedge wclk) begin
    if (!w_run) wptr <= WR_HOME;
    else        wptr <= {wptr[DEPTH-2:0], wptr[DEPTH-1]};
  end

  always_ff @(posedge wclk) begin
    if (!w_run) begin
      for (int i = 0; i < SYNC; i++) rsync[i] <= RD_HOME;
    end else begin
      rsync[0] <= rd_ptr;
      for (int i = 1; i < SYNC; i++) rsync[i] <= rsync[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge wclk) begin
      if (!w_run)      q <= '0;
      else if (wptr[g]) q <= din;
    end
    assign store[g] = q;
  end

  assign gap   = ring_gap(oh_index(32'(wptr)), oh_index(32'(rsync[SYNC-1])), DEPTH);
  assign alarm = w_run && gap_bad(gap, GAP_NOM, SLACK);

  always_ff @(posedge wclk) begin
    if (!w_run)              hold_cnt <= '0;
    else if (alarm)          hold_cnt <= CW'(WARN_MIN);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign warn_n = (hold_cnt == '0);

  // Length of the current low stretch of warn_n, used only by the checks.
  logic [7:0] low_len;
  always_ff @(posedge wclk) begin
    if (!w_run)       low_len <= '0;
    else if (!warn_n) low_len <= (low_len == 8'hFF) ? low_len : low_len + 8'd1;
    else              low_len <= '0;
  end

  // R6
  alarm_warns_chk: assert property (@(posedge wclk) disable iff (!w_run)
    alarm |=> !warn_n);

  // R8
  warn_hold_chk: assert property (@(posedge wclk) disable iff (!w_run)
    $rose(warn_n) |-> (32'(low_len) >= WARN_MIN));
endmodule

// File: rtl/phf_rd_side.sv
module phf_rd_side
  import phf_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 5
) (
  input  logic                    rclk,
  input  logic                    r_run,
  input  logic [W-1:0]            din,
  input  logic [DEPTH-1:0][W-1:0] store,
  output logic [DEPTH-1:0]        rd_ptr,
  output logic [W-1:0]            rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DEPTH-1:0] RD_HOME = DEPTH'(1);

  logic [IW-1:0] rsel;
  assign rsel = IW'(oh_index(32'(rd_ptr)));

  always_ff @(posedge rclk) begin
    if (!r_run) rd_ptr <= RD_HOME;
    else        rd_ptr <= {rd_ptr[DEPTH-2:0], rd_ptr[DEPTH-1]};
  end

  always_ff @(posedge rclk) begin
    if (!r_run) rdata <= din;
    else        rdata <= store[rsel];
  end

  // R1
  bypass_path_chk: assert property (@(posedge rclk) disable iff (r_run)
    1'b1 |=> (rdata == $past(din)));

  // R3
  first_zero_chk: assert property (@(posedge rclk) disable iff (!r_run)
    $rose(r_run) |=> (rdata == '0));
endmodule

// File: rtl/phase_fifo.sv
module phase_fifo #(
  parameter int W          = 16,
  parameter int DEPTH      = 5,
  parameter int START_GAP  = 2,
  parameter int SYNC       = 2,
  parameter int WARN_MIN   = 5
) (
  input  logic         rst_n,
  input  logic         wclk,
  input  logic [W-1:0] din,
  output logic         warn_n,
  input  logic         rclk,
  output logic [W-1:0] rdata
);
  localparam int SLACK = 1;

  logic                    w_run;
  logic                    r_run;
  logic [DEPTH-1:0]        rd_ptr;
  logic [DEPTH-1:0][W-1:0] store;

  phf_run_sync #(.STAGES(SYNC)) u_wsync (
    .clk(wclk), .arst_n(rst_n), .run(w_run)
  );

  phf_run_sync #(.STAGES(SYNC)) u_rsync (
    .clk(rclk), .arst_n(rst_n), .run(r_run)
  );

  phf_wr_side #(
    .W(W), .DEPTH(DEPTH), .START(START_GAP), .SYNC(SYNC),
    .SLACK(SLACK), .WARN_MIN(WARN_MIN)
  ) u_wr (
    .wclk(wclk), .w_run(w_run), .din(din), .rd_ptr(rd_ptr),
    .store(store), .warn_n(warn_n)
  );

  phf_rd_side #(.W(W), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .r_run(r_run), .din(din), .store(store),
    .rd_ptr(rd_ptr), .rdata(rdata)
  );
endmodule

// File: tb/tb_phase_fifo.sv
`timescale 1ns/1ps
module tb_phase_fifo;
  logic        rst_n;
  logic        wclk;
  logic        rclk;
  logic [15:0] din;
  logic [15:0] rdata;
  logic        warn_n;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  real pend  = 0.0;

  phase_fifo dut (
    .rst_n(rst_n), .wclk(wclk), .din(din), .warn_n(warn_n),
    .rclk(rclk), .rdata(rdata)
  );

  // 200 MHz write clock; pend stretches or shrinks one low phase.
  initial begin
    real extra;
    wclk = 1'b0;
    #0.01;
    forever begin
      wclk = 1'b1;
      #2.5;
      wclk = 1'b0;
      extra = pend;
      pend  = 0.0;
      #(2.5 + extra);
    end
  end

  // 200 MHz read clock, half a period behind the write clock.
  initial begin
    rclk = 1'b0;
    #2.51;
    forever begin
      rclk = 1'b1; #2.5;
      rclk = 1'b0; #2.5;
    end
  end

  // Upstream source: a new word 1 ns after each write edge.
  initial begin
    din = 16'h0100;
    forever begin
      @(posedge wclk);
      #1;
      din = din + 16'd1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic get_rd(output logic [15:0] v);
    @(negedge rclk);
    #0.25;
    v = rdata;
  endtask

  task automatic wr_cycles(input int n);
    repeat (n) @(posedge wclk);
    #1.25;
  endtask

  task automatic check_stream(input int n, input string req);
    logic [15:0] v, nv;
    int bad;
    bad = 0;
    get_rd(v);
    for (int i = 0; i < n; i++) begin
      get_rd(nv);
      if (nv != v + 16'd1 && bad == 0) begin
        chk(1'b0, req, nv, v + 16'd1);
        bad = 1;
      end
      if (!warn_n && bad == 0) begin
        chk(1'b0, {req, " warn"}, 0, 1);
        bad = 1;
      end
      v = nv;
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  // Shift the write clock phase by steps*per ns; report if warn_n dropped.
  task automatic drift(input int steps, input real per, output bit saw_low);
    saw_low = 0;
    repeat (steps) begin
      @(posedge wclk);
      #1.25;
      if (!warn_n) saw_low = 1;
      pend = per;
    end
    repeat (4) begin
      @(posedge wclk);
      #1.25;
      if (!warn_n) saw_low = 1;
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    wr_cycles(8);
    chk(warn_n == 1'b1, "R2 warn high in reset", warn_n, 1);
    for (int i = 0; i < 3; i++) begin
      get_rd(v);
      chk(v == din, "R1 transparent path", v, din);
    end
  endtask

  task automatic t_release();
    logic [15:0] d0;
    logic [15:0] s [5];
    @(posedge wclk);
    #0.5;
    d0 = din;
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) get_rd(s[i]);
    chk(s[0] == d0 + 16'd1, "R1 bypass before read start", s[0], d0 + 16'd1);
    chk(s[1] == d0 + 16'd2, "R1 bypass before read start", s[1], d0 + 16'd2);
    chk(s[2] == 16'd0, "R3 first zero word", s[2], 0);
    chk(s[3] == 16'd0, "R3 second zero word", s[3], 0);
    chk(s[4] == d0 + 16'd3, "R4 first stored word", s[4], d0 + 16'd3);
    chk(warn_n == 1'b1, "R9 warn high after start", warn_n, 1);
  endtask

  task automatic t_small_drift();
    bit low;
    drift(10, 0.5, low);
    chk(!low, "R5 late drift one period no warn", low, 0);
    check_stream(40, "R5 stream after late drift");
    drift(10, -0.5, low);
    chk(!low, "R5 drift back no warn", low, 0);
    drift(10, -0.5, low);
    chk(!low, "R5 early drift one period no warn", low, 0);
    check_stream(40, "R5 stream after early drift");
    drift(10, 0.5, low);
    chk(!low, "R5 return to nominal no warn", low, 0);
  endtask

  task automatic t_overflow(input real per, input string req);
    bit low;
    int lows;
    drift(20, per, low);
    chk(low, {req, " warn raised"}, low, 1);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      wr_cycles(1);
      if (!warn_n) lows++;
    end
    chk(lows == 20, "R8 warn held while collision lasts", lows, 20);
  endtask

  task automatic t_reset_clears();
    rst_n = 1'b0;
    wr_cycles(8);
    chk(warn_n == 1'b1, "R9 reset clears warn", warn_n, 1);
    chk(warn_n == 1'b1, "R2 warn high in reset", warn_n, 1);
    t_release();
    check_stream(20, "R9 clean stream after new reset");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_release();
    check_stream(40, "R4 steady stream");
    t_small_drift();
    check_stream(20, "R5 stream at nominal");
    t_overflow(0.5, "R6 late collision");
    t_reset_clears();
    t_overflow(-0.5, "R7 early collision");
    t_reset_clears();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule